// File: doc/BRIEF.md
# Complement-Key Kicked Watchdog

This block is a two-stage watchdog timer driven through one 32-bit control word. Software writes the word to load a reload count, to choose between starting and stopping the countdown, and to present a 7-bit key. While the watchdog is armed, a write is honoured only if its key is the bitwise inverse of the key held from the last honoured write. Code that has run away and keeps writing the same value therefore cannot keep the watchdog quiet.

The countdown advances once per cycle in which the `tick` input is high. The tick input stands for an external prescaler. When the first countdown runs out, the block raises a non-maskable interrupt line and reloads a short grace count. If that grace count also runs out before a valid kick arrives, the block emits a one-cycle system reset request and then stays stopped until the next honoured write. A valid kick at any time clears the interrupt and restarts the sequence from the first stage.

Top module: `kick_watchdog`

## Requirements
- R1: The control word places the reload count in bits [7:0], the start command in bit 8 and the key in bits [15:9]. An honoured write stores all 32 bits, and they are visible on `ctrl_rdata` from the cycle after the write.
- R2: While bit 8 of the stored word is 0, every write is honoured whatever its key, and its key becomes the reference for the next comparison.
- R3: While bit 8 of the stored word is 1, a write whose key is not the bitwise inverse of the stored key changes neither the stored word, nor the countdown, nor the outputs.
- R4: An honoured write with bit 8 set loads count N and starts the countdown. `nmi` goes high after the clock edge that samples the Nth tick following the write, and not before.
- R5: A reload count of 0 gives a first stage of 256 ticks.
- R6: An honoured write with bit 8 clear stops the countdown. No later tick raises `nmi` or `reset_req` until the countdown is started again.
- R7: The countdown advances only on cycles in which `tick` is high. Cycles with `tick` low leave it unchanged.
- R8: After the first expiry, `nmi` stays high and a grace count of GRACE_TICKS ticks (default 1) begins. When it runs out, `reset_req` is high for exactly one cycle. After that the countdown is stopped, and no further request follows without a new honoured write.
- R9: An honoured write drops `nmi` in the next cycle and returns the block to the first stage, so a kick made during the grace period prevents the reset request.
- R10: Synchronous active-low reset clears the stored word to 0, stops the countdown and drives `nmi` and `reset_req` low.
- R11: When an honoured write and a tick share a clock edge, the write takes priority. The new count is loaded as written, and that tick neither decrements it nor causes an expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Control word being written |
| tick | input | 1 | Countdown enable from the prescaler |
| ctrl_rdata | output | 32 | Stored control word |
| nmi | output | 1 | Non-maskable interrupt, set by the first expiry |
| reset_req | output | 1 | One-cycle system reset request, set by the grace expiry |

## Verification
Every reload count from 0 to 255 is run through the full first-stage, grace and reset-request sequence with `tick` held high. Checking `nmi` one tick before and exactly on the expected tick separates off-by-one loads and a wrong zero-means-256 mapping. All 127 incorrect keys are written against an armed watchdog. A countdown that then expires on its original schedule shows that none of those writes leaked into the counter. Further patterns cover the following:
- a gapped tick train, which tells tick-gated counting apart from free running;
- a kick during grace, which tells stage clearing apart from a bare reload;
- a write on a tick edge, which shows write priority.

// File: rtl/wdg_pkg.sv
// Package wdg_pkg
// Shared types for the kicked watchdog. It holds the expiry stage
// encoding used between the stage tracker and the counter.
package wdg_pkg;
    typedef enum logic {
        STG_WATCH = 1'b0,   // first countdown in progress
        STG_GRACE = 1'b1    // first expiry seen, grace countdown running
    } wdg_stage_e;
endpackage

// File: rtl/wdg_key_gate.sv
// Module wdg_key_gate
// Holds the control word and decides whether a write is honoured.
// A write is honoured when the stored start bit is clear, or when the new
// key is the bitwise inverse of the stored key.
// Assumes the field layout count[CNT_W-1:0], start[CNT_W], key above that.
module wdg_key_gate #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 8,
    parameter int KEY_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              accept,
    output logic              cmd_start,
    output logic [CNT_W-1:0]  cmd_count,
    output logic [DATA_W-1:0] ctrl_q
);
    localparam int EN_BIT  = CNT_W;
    localparam int KEY_LSB = CNT_W + 1;

    logic [KEY_W-1:0] key_held;
    logic [KEY_W-1:0] key_new;
    logic             armed;

    assign key_held  = ctrl_q[KEY_LSB +: KEY_W];
    assign key_new   = wr_data[KEY_LSB +: KEY_W];
    assign armed     = ctrl_q[EN_BIT];
    assign cmd_start = wr_data[EN_BIT];
    assign cmd_count = wr_data[CNT_W-1:0];

    // Decide acceptance: any key while disarmed, inverse key while armed.
    always_comb begin
        accept = wr_en && (!armed || (key_new == ~key_held));
    end

    // Store the control word on every honoured write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (accept) begin
            ctrl_q <= wr_data;
        end
    end
endmodule

// File: rtl/wdg_countdown.sv
// Module wdg_countdown
// Tick-gated down counter. An honoured write loads it (0 means 2**CNT_W)
// and starts or stops it. Expiry fires on the tick that would take the
// count from 1 to 0. On the first-stage expiry it reloads the grace count.
// On the grace expiry it stops. A load beats a tick on the same edge.
module wdg_countdown #(
    parameter int CNT_W       = 8,
    parameter int GRACE_TICKS = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic             start,
    input  logic [CNT_W-1:0] load_cnt,
    input  logic             in_grace,
    output logic             expire
);
    localparam int            CW      = CNT_W + 1;
    localparam logic [CW-1:0] FULL    = CW'(1) << CNT_W;
    localparam logic [CW-1:0] GRACE_V = CW'(GRACE_TICKS);

    logic [CW-1:0] cnt_q;
    logic          run_q;
    logic [CW-1:0] load_val;

    // Map a written count of zero onto the full range.
    always_comb begin
        load_val = (load_cnt == '0) ? FULL : {1'b0, load_cnt};
    end

    // Flag the tick that exhausts the running count.
    always_comb begin
        expire = run_q && tick && !load && (cnt_q == CW'(1));
    end

    // Load, reload for grace, stop after grace, or decrement on a tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (load) begin
            cnt_q <= load_val;
            run_q <= start;
        end else if (expire) begin
            if (in_grace) begin
                cnt_q <= '0;
                run_q <= 1'b0;
            end else begin
                cnt_q <= GRACE_V;
            end
        end else if (run_q && tick) begin
            cnt_q <= cnt_q - CW'(1);
        end
    end
endmodule

// File: rtl/wdg_stage.sv
// Module wdg_stage
// Tracks which expiry stage the watchdog is in. It drives the interrupt
// (held from the first expiry until an honoured write) and the one-cycle
// reset request (on the grace expiry). An honoured write returns it to
// the first stage.
module wdg_stage
    import wdg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic expire,
    output logic in_grace,
    output logic nmi,
    output logic reset_req
);
    wdg_stage_e stage_q;

    assign in_grace = (stage_q == STG_GRACE);

    // Advance stage on expiry, pulse the request, and clear on an honoured write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q   <= STG_WATCH;
            nmi       <= 1'b0;
            reset_req <= 1'b0;
        end else begin
            reset_req <= 1'b0;
            if (clear) begin
                stage_q <= STG_WATCH;
                nmi     <= 1'b0;
            end else if (expire) begin
                if (stage_q == STG_WATCH) begin
                    stage_q <= STG_GRACE;
                    nmi     <= 1'b1;
                end else begin
                    reset_req <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/kick_watchdog.sv
// Module kick_watchdog
// Two-stage watchdog kicked through one control word that carries an
// inverting key. It connects the key gate, the countdown and the stage
// tracker. Assumes a single clock domain with tick already synchronous.
module kick_watchdog #(
    parameter int DATA_W      = 32,
    parameter int CNT_W       = 8,
    parameter int KEY_W       = 7,
    parameter int GRACE_TICKS = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              tick,
    output logic [DATA_W-1:0] ctrl_rdata,
    output logic              nmi,
    output logic              reset_req
);
    logic             accept;
    logic             cmd_start;
    logic [CNT_W-1:0] cmd_count;
    logic             expire;
    logic             in_grace;

    wdg_key_gate #(.DATA_W(DATA_W), .CNT_W(CNT_W), .KEY_W(KEY_W)) u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .accept    (accept),
        .cmd_start (cmd_start),
        .cmd_count (cmd_count),
        .ctrl_q    (ctrl_rdata)
    );

    wdg_countdown #(.CNT_W(CNT_W), .GRACE_TICKS(GRACE_TICKS)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .load     (accept),
        .start    (cmd_start),
        .load_cnt (cmd_count),
        .in_grace (in_grace),
        .expire   (expire)
    );

    wdg_stage u_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (accept),
        .expire    (expire),
        .in_grace  (in_grace),
        .nmi       (nmi),
        .reset_req (reset_req)
    );
endmodule

// File: rtl/wdg_checker.sv
// Module wdg_checker
// Port-level temporal checks for kick_watchdog, attached by bind below.
module wdg_checker #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 8,
    parameter int KEY_W  = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic [DATA_W-1:0] ctrl_rdata,
    input logic              nmi,
    input logic              reset_req
);
    localparam int EN_BIT  = CNT_W;
    localparam int KEY_LSB = CNT_W + 1;

    logic key_ok;
    logic was_rst;

    assign key_ok = (wr_data[KEY_LSB +: KEY_W] == ~ctrl_rdata[KEY_LSB +: KEY_W]);

    // Remember that reset was sampled low at the last edge.
    always_ff @(posedge clk) begin
        was_rst <= !rst_n;
    end

    // R10: everything is clear after a reset edge.
    always @(negedge clk) begin
        if (was_rst) begin
            assert_reset_clear_R10: assert (ctrl_rdata == '0 && !nmi && !reset_req);
        end
    end

    // R3: a wrong key against an armed word leaves the word untouched.
    assert_reject_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ctrl_rdata[EN_BIT] && !key_ok) |=> $stable(ctrl_rdata));

    // R1, R2, R9: an honoured write is stored and clears both alarm outputs.
    assert_kick_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (!ctrl_rdata[EN_BIT] || key_ok))
        |=> (ctrl_rdata == $past(wr_data)) && !nmi && !reset_req);

    // R8: the reset request lasts one cycle.
    assert_req_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |=> !reset_req);

    // R8: the reset request only follows an interrupt that is still pending.
    assert_req_after_nmi_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reset_req) |-> nmi);
endmodule

bind kick_watchdog wdg_checker #(
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W),
    .KEY_W  (KEY_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .ctrl_rdata (ctrl_rdata),
    .nmi        (nmi),
    .reset_req  (reset_req)
);

// File: tb/sim_kick_watchdog.sv
module sim_kick_watchdog;
    localparam int GRACE = 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        tick = 1'b0;
    logic [31:0] ctrl_rdata;
    logic        nmi;
    logic        reset_req;

    int errors = 0;
    int checks = 0;
    logic [6:0] ref_key = '0;
    logic       armed = 1'b0;

    always #4 clk = ~clk;

    kick_watchdog #(.GRACE_TICKS(GRACE)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .tick(tick), .ctrl_rdata(ctrl_rdata), .nmi(nmi), .reset_req(reset_req)
    );

    function automatic logic [31:0] word(input logic [6:0] key, input logic st,
                                         input logic [7:0] cnt);
        return {16'h0, key, st, cnt};
    endfunction

    task automatic check(input logic ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Raw write at the next edge, with optional simultaneous tick.
    task automatic raw_write(input logic [31:0] d, input logic t);
        wr_en = 1'b1; wr_data = d; tick = t;
        @(negedge clk);
        wr_en = 1'b0; tick = 1'b0;
    endtask

    // Honoured write using the correct key; returns the word written.
    task automatic kick(input logic st, input logic [7:0] cnt, input logic [6:0] free_key,
                        input logic t, output logic [31:0] d);
        logic [6:0] k;
        k = armed ? ~ref_key : free_key;
        d = word(k, st, cnt);
        raw_write(d, t);
        ref_key = k;
        armed = st;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1;
            @(negedge clk);
        end
        tick = 1'b0;
    endtask

    initial begin
        logic [31:0] d;
        logic [31:0] held;
        @(negedge clk); @(negedge clk);
        // R10: reset state
        check(ctrl_rdata == 0, "R10 ctrl", ctrl_rdata, 0);
        check(!nmi, "R10 nmi", {31'h0, nmi}, 0);
        check(!reset_req, "R10 reset_req", {31'h0, reset_req}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: disarmed, any key is honoured
        raw_write(word(7'h2A, 1'b0, 8'd5), 1'b0);
        check(ctrl_rdata == word(7'h2A, 1'b0, 8'd5), "R2 first", ctrl_rdata, word(7'h2A, 1'b0, 8'd5));
        raw_write(word(7'h13, 1'b0, 8'd7), 1'b0);
        check(ctrl_rdata == word(7'h13, 1'b0, 8'd7), "R2 any key", ctrl_rdata, word(7'h13, 1'b0, 8'd7));
        ref_key = 7'h13; armed = 1'b0;
        // R6: stopped, ticks do nothing
        ticks(300);
        check(!nmi && !reset_req, "R6 stopped idle", {30'h0, nmi, reset_req}, 0);

        // R1 R4 R5 R8: sweep every reload count
        for (int n = 0; n < 256; n++) begin
            int e;
            e = (n == 0) ? 256 : n;
            kick(1'b1, 8'(n), 7'(n * 37), 1'b0, d);
            check(ctrl_rdata == d, "R1 stored word", ctrl_rdata, d);
            ticks(e - 1);
            check(!nmi, (n == 0) ? "R5 early nmi" : "R4 early nmi", {31'h0, nmi}, 0);
            ticks(1);
            check(nmi && !reset_req, (n == 0) ? "R5 nmi on time" : "R4 nmi on time",
                  {30'h0, nmi, reset_req}, 2);
            ticks(GRACE);
            check(reset_req && nmi, "R8 request", {30'h0, nmi, reset_req}, 3);
            for (int j = 0; j < 3; j++) begin
                ticks(1);
                check(!reset_req, "R8 single pulse", {31'h0, reset_req}, 0);
            end
        end

        // R3: every wrong key against an armed word is ignored
        kick(1'b1, 8'd200, 7'h00, 1'b0, d);
        held = d;
        for (int b = 0; b < 128; b++) begin
            if (7'(b) != ~ref_key) begin
                raw_write(word(7'(b), 1'b1, 8'd1), 1'b0);
                check(ctrl_rdata == held, "R3 rejected", ctrl_rdata, held);
            end
        end
        ticks(199);
        check(!nmi, "R3 counter untouched early", {31'h0, nmi}, 0);
        ticks(1);
        check(nmi, "R3 counter untouched expiry", {31'h0, nmi}, 1);

        // R6: honoured stop halts the countdown
        kick(1'b1, 8'd10, 7'h00, 1'b0, d);
        check(!nmi, "R9 kick clears nmi", {31'h0, nmi}, 0);
        ticks(4);
        kick(1'b0, 8'd10, 7'h00, 1'b0, d);
        ticks(300);
        check(!nmi && !reset_req, "R6 stop", {30'h0, nmi, reset_req}, 0);

        // R9: kick during grace returns to first stage
        kick(1'b1, 8'd2, 7'h41, 1'b0, d);
        ticks(2);
        check(nmi, "R9 setup nmi", {31'h0, nmi}, 1);
        kick(1'b1, 8'd3, 7'h00, 1'b0, d);
        check(!nmi, "R9 nmi dropped", {31'h0, nmi}, 0);
        ticks(2);
        check(!nmi && !reset_req, "R9 no request", {30'h0, nmi, reset_req}, 0);
        ticks(1);
        check(nmi && !reset_req, "R9 first stage again", {30'h0, nmi, reset_req}, 2);
        ticks(GRACE);
        check(reset_req, "R9 then request", {31'h0, reset_req}, 1);

        // R11: write on a tick edge wins
        kick(1'b1, 8'd2, 7'h00, 1'b0, d);
        ticks(1);
        kick(1'b1, 8'd3, 7'h00, 1'b1, d);
        check(!nmi, "R11 no expiry on write edge", {31'h0, nmi}, 0);
        ticks(2);
        check(!nmi, "R11 full count loaded", {31'h0, nmi}, 0);
        ticks(1);
        check(nmi, "R11 expiry", {31'h0, nmi}, 1);

        // R7: gapped ticks
        kick(1'b1, 8'd4, 7'h00, 1'b0, d);
        for (int i = 0; i < 3; i++) begin
            ticks(1);
            @(negedge clk);
        end
        check(!nmi, "R7 three gapped ticks", {31'h0, nmi}, 0);
        repeat (5) @(negedge clk);
        check(!nmi, "R7 idle cycles", {31'h0, nmi}, 0);
        ticks(1);
        check(nmi, "R7 fourth tick", {31'h0, nmi}, 1);

        // R10: reset mid-run
        rst_n = 1'b0;
        @(negedge clk);
        check(ctrl_rdata == 0 && !nmi && !reset_req, "R10 mid-run reset",
              {ctrl_rdata[29:0], nmi, reset_req}, 0);
        rst_n = 1'b1;
        ticks(300);
        check(!nmi && !reset_req, "R10 stopped after reset", {30'h0, nmi, reset_req}, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog timeout actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule